// File: doc/BRIEF.md
# System Clock Source and Stop-Mode Controller

This block decides where the core and bus clocks come from and how the crystal oscillator behaves while the chip is stopped. A select bit picks the phase-locked loop (1) or the oscillator (0) as the system clock source. The glitch-free switching cell is modelled as this ideal mux select. The bus clock runs at half the rate of the chosen source. It is modelled as a clock enable that pulses on every second cycle while the block is running. The oscillator and the PLL are not modelled in analog form. The oscillator shows up only as a ready flag.

Software programs two control bits through a write port: the source select and a pseudo-stop bit. Hardware guards the select bit. It returns the select bit to the PLL whenever the oscillator is not ready and whenever full stop is entered. A software clear of the select bit is refused while the oscillator is not ready.

A stop request moves the block from running into one of two modes, chosen by the pseudo-stop bit. In full stop the oscillator is switched off. In pseudo stop it keeps running. A stop-exit event returns the block to running. Register writes are ignored in both stop modes.

The mode controller has three states: ST_RUN, ST_FULL_STOP and ST_PSEUDO_STOP. It has three named transitions:
- T_STOP_FULL goes from ST_RUN to ST_FULL_STOP, on a stop request while the pseudo-stop bit is 0.
- T_STOP_PSEUDO goes from ST_RUN to ST_PSEUDO_STOP, on a stop request while the pseudo-stop bit is 1.
- T_WAKE goes from either stop state back to ST_RUN, on a stop-exit event.

Top module: `sysclk_stop_ctrl`

## Requirements
- R1: After reset, `src_sel` is 1, the pseudo-stop bit is 0, `mode` is 0 (run), `osc_en` is 1 and `bus_ce` is 0.
- R2: In run mode, a write (`wr_en`=1) loads `wr_sel_pll` into `src_sel` at the next edge when `osc_ready` is 1. A write loads `wr_keep_osc` into the pseudo-stop bit at the next edge.
- R3: A write of 0 to the select bit while `osc_ready` is 0 leaves `src_sel` at 1.
- R4: Whenever `osc_ready` is 0 at a clock edge, `src_sel` is 1 after that edge, in every mode.
- R5: In run mode, a stop request while the pseudo-stop bit is 0 makes `mode` 1 (full stop) after the next edge. It also sets `src_sel` to 1 and drops `osc_en` to 0. The decision uses the pseudo-stop value held before that edge.
- R6: In run mode, a stop request while the pseudo-stop bit is 1 makes `mode` 2 (pseudo stop) after the next edge. `osc_en` stays 1 and `src_sel` is kept.
- R7: In either stop mode, `stop_exit` returns `mode` to 0 at the next edge. Without it, the stop mode is held. In run mode, `stop_exit` has no effect.
- R8: While `mode` is 1 or 2, writes change neither `src_sel` nor the pseudo-stop bit.
- R9: In run mode, `bus_ce` alternates 0,1,0,1, starting with 0 on the first run cycle after reset or after a stop. In stop modes, `bus_ce` is 0.
- R10: A software clear of the select bit on the same edge as full-stop entry loses: `src_sel` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel_pll | input | 1 | Written value of the source select bit (1 = PLL) |
| wr_keep_osc | input | 1 | Written value of the pseudo-stop bit |
| osc_ready | input | 1 | Oscillator has started and is stable |
| stop_req | input | 1 | Request to enter a stop mode |
| stop_exit | input | 1 | Wake event that ends a stop mode |
| src_sel | output | 1 | System clock source select, 1 = PLL, 0 = oscillator |
| bus_ce | output | 1 | Bus clock enable, half the source rate |
| osc_en | output | 1 | Oscillator enable |
| mode | output | 2 | 0 run, 1 full stop, 2 pseudo stop |

## Verification
The hardest situation to reach is a collision on one edge. In it, a software clear of the select bit, a stop request and the current pseudo-stop value all meet while the oscillator is ready. Only then does the full-stop override decide the result. A directed sequence first brings `src_sel` to 0 with the pseudo-stop bit at 0, then applies the clear and the stop request together.

Writes that are ignored during stop cannot be seen until the block is back in run. So the bench wakes the block and issues a second stop request to read back the pseudo-stop bit through the mode it chooses. A long pseudo-random sweep over all six inputs then compares every output against an arithmetic model of the requirements.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        ST_RUN         = 2'd0,
        ST_FULL_STOP   = 2'd1,
        ST_PSEUDO_STOP = 2'd2
    } mode_e;

endpackage

// File: rtl/stop_mode_fsm.sv
module stop_mode_fsm
    import sysclk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stop_req,
    input  logic  stop_exit,
    input  logic  pseudo_bit,
    output mode_e state,
    output logic  in_run,
    output logic  enter_full,
    output logic  osc_en
);

    mode_e state_d;

    // Next-state selection; transitions T_STOP_FULL, T_STOP_PSEUDO, T_WAKE
    always_comb begin
        state_d = state;
        unique case (state)
            ST_RUN: begin
                if (stop_req) begin
                    state_d = pseudo_bit ? ST_PSEUDO_STOP : ST_FULL_STOP;
                end
            end
            ST_FULL_STOP: begin
                if (stop_exit) begin
                    state_d = ST_RUN;
                end
            end
            ST_PSEUDO_STOP: begin
                if (stop_exit) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_d;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        in_run     = 1'b0;
        enter_full = 1'b0;
        osc_en     = 1'b1;
        unique case (state)
            ST_RUN: begin
                in_run     = 1'b1;
                enter_full = stop_req && !pseudo_bit;
            end
            ST_FULL_STOP: begin
                osc_en = 1'b0;
            end
            ST_PSEUDO_STOP: begin
                osc_en = 1'b1;
            end
            default: begin
                in_run = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/clk_src_select.sv
module clk_src_select (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_sel_pll,
    input  logic wr_keep_osc,
    input  logic osc_ready,
    input  logic in_run,
    input  logic enter_full,
    output logic src_sel,
    output logic pseudo_bit
);

    logic wr_ok;
    logic sel_d;

    assign wr_ok = wr_en && in_run;

    // Hardware forcing to the PLL takes priority over software
    always_comb begin
        if (!osc_ready || enter_full) begin
            sel_d = 1'b1;
        end else if (wr_ok) begin
            sel_d = wr_sel_pll;
        end else begin
            sel_d = src_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel    <= 1'b1;
            pseudo_bit <= 1'b0;
        end else begin
            src_sel <= sel_d;
            if (wr_ok) begin
                pseudo_bit <= wr_keep_osc;
            end
        end
    end

endmodule

// File: rtl/bus_ce_div.sv
module bus_ce_div #(
    parameter int BUS_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic bus_ce
);

    generate
        if (BUS_DIV <= 1) begin : g_pass
            assign bus_ce = run;
        end else begin : g_cnt
            localparam int CNT_W = $clog2(BUS_DIV);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(BUS_DIV - 1);
            logic [CNT_W-1:0] cnt;

            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign bus_ce = run && (cnt == LAST);
        end
    endgenerate

endmodule

// File: rtl/sysclk_stop_ctrl.sv
module sysclk_stop_ctrl
    import sysclk_pkg::*;
#(
    parameter int BUS_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel_pll,
    input  logic              wr_keep_osc,
    input  logic              osc_ready,
    input  logic              stop_req,
    input  logic              stop_exit,
    output logic              src_sel,
    output logic              bus_ce,
    output logic              osc_en,
    output logic [MODE_W-1:0] mode
);

    mode_e state;
    logic  in_run;
    logic  enter_full;
    logic  pseudo_bit;

    stop_mode_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_req   (stop_req),
        .stop_exit  (stop_exit),
        .pseudo_bit (pseudo_bit),
        .state      (state),
        .in_run     (in_run),
        .enter_full (enter_full),
        .osc_en     (osc_en)
    );

    clk_src_select i_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel_pll  (wr_sel_pll),
        .wr_keep_osc (wr_keep_osc),
        .osc_ready   (osc_ready),
        .in_run      (in_run),
        .enter_full  (enter_full),
        .src_sel     (src_sel),
        .pseudo_bit  (pseudo_bit)
    );

    bus_ce_div #(.BUS_DIV(BUS_DIV)) i_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (in_run),
        .bus_ce (bus_ce)
    );

    assign mode = state;

endmodule

// File: rtl/sysclk_stop_ctrl_chk.sv
module sysclk_stop_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       osc_ready,
    input logic       stop_req,
    input logic       stop_exit,
    input logic       src_sel,
    input logic       bus_ce,
    input logic [1:0] mode
);

    AST_NOT_READY_FORCES_PLL: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_ready |=> src_sel); // R4

    AST_CLEAR_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(src_sel) |-> ($past(osc_ready) && $past(wr_en) && $past(mode) == 2'd0)); // R3

    AST_FULL_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode == 2'd1) |-> ($past(mode) == 2'd0 && $past(stop_req))); // R5

    AST_FULL_STOP_ON_PLL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |-> src_sel); // R10

    AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0 && stop_exit) |=> (mode == 2'd0)); // R7

    AST_STOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0 && !stop_exit) |=> $stable(mode)); // R7

    AST_STOP_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0 && osc_ready) |=> $stable(src_sel)); // R8

    AST_CE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0) |-> !bus_ce); // R9

    AST_CE_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ce |=> !bus_ce); // R9

endmodule

bind sysclk_stop_ctrl sysclk_stop_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .osc_ready (osc_ready),
    .stop_req  (stop_req),
    .stop_exit (stop_exit),
    .src_sel   (src_sel),
    .bus_ce    (bus_ce),
    .mode      (mode)
);

// File: tb/test_sysclk_stop_ctrl.sv
module test_sysclk_stop_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel_pll = 1'b0;
    logic       wr_keep_osc = 1'b0;
    logic       osc_ready = 1'b0;
    logic       stop_req = 1'b0;
    logic       stop_exit = 1'b0;
    logic       src_sel;
    logic       bus_ce;
    logic       osc_en;
    logic [1:0] mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the requirements
    int m_mode = 0;
    int m_sel = 1;
    int m_ps = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    sysclk_stop_ctrl i_sysclk_stop_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel_pll  (wr_sel_pll),
        .wr_keep_osc (wr_keep_osc),
        .osc_ready   (osc_ready),
        .stop_req    (stop_req),
        .stop_exit   (stop_exit),
        .src_sel     (src_sel),
        .bus_ce      (bus_ce),
        .osc_en      (osc_en),
        .mode        (mode)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input bit we, input bit ws, input bit wp, input bit rdy,
                         input bit sreq, input bit sx);
        wr_en = we; wr_sel_pll = ws; wr_keep_osc = wp;
        osc_ready = rdy; stop_req = sreq; stop_exit = sx;
    endtask

    // One edge; model advanced from the requirements, result sampled at negedge
    task automatic step();
        int run;
        int full;
        int n_sel;
        int n_ps;
        int n_mode;
        run   = (m_mode == 0) ? 1 : 0;
        full  = (run == 1 && stop_req && m_ps == 0) ? 1 : 0;
        n_sel = (!osc_ready || full == 1) ? 1 : ((wr_en && run == 1) ? int'(wr_sel_pll) : m_sel);
        n_ps  = (wr_en && run == 1) ? int'(wr_keep_osc) : m_ps;
        if (run == 1) n_mode = stop_req ? ((m_ps == 1) ? 2 : 1) : 0;
        else          n_mode = stop_exit ? 0 : m_mode;
        m_cnt  = (run == 1) ? (1 - m_cnt) : 0;
        m_sel  = n_sel;
        m_ps   = n_ps;
        m_mode = n_mode;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_ce();
        return (m_mode == 0 && m_cnt == 1) ? 1 : 0;
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        drive(0, 0, 0, 1, 0, 0);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 src_sel", src_sel, 1);
        chk("R1 mode", mode, 0);
        chk("R1 osc_en", osc_en, 1);
        chk("R1 bus_ce", bus_ce, 0);

        // R9: alternating enable in run
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R9 bus_ce alternate", bus_ce, (k % 2 == 0) ? 1 : 0);
        end

        // R2: clear and set with oscillator ready
        drive(1, 0, 0, 1, 0, 0); step();
        chk("R2 clear src_sel", src_sel, 0);
        drive(1, 1, 0, 1, 0, 0); step();
        chk("R2 set src_sel", src_sel, 1);

        // R3: clear refused without ready
        drive(1, 0, 0, 0, 0, 0); step();
        chk("R3 clear refused", src_sel, 1);

        // R4: ready drop forces PLL
        drive(1, 0, 0, 1, 0, 0); step();
        chk("R4 setup clear", src_sel, 0);
        drive(0, 0, 0, 0, 0, 0); step();
        chk("R4 forced to PLL", src_sel, 1);

        // R5: full stop (pseudo bit 0 from reset)
        drive(1, 0, 0, 1, 0, 0); step();
        drive(0, 0, 0, 1, 1, 0); step();
        chk("R5 mode full", mode, 1);
        chk("R5 src_sel", src_sel, 1);
        chk("R5 osc_en", osc_en, 0);
        chk("R9 bus_ce in stop", bus_ce, 0);
        // R7: held without exit, then wake
        drive(0, 0, 0, 1, 0, 0); step();
        chk("R7 stop held", mode, 1);
        drive(0, 0, 0, 1, 0, 1); step();
        chk("R7 wake", mode, 0);
        chk("R9 first run cycle", bus_ce, 0);
        drive(0, 0, 0, 1, 0, 1); step();
        chk("R7 exit in run ignored", mode, 0);

        // R6: pseudo stop keeps oscillator and select
        drive(1, 0, 1, 1, 0, 0); step();
        drive(0, 0, 0, 1, 1, 0); step();
        chk("R6 mode pseudo", mode, 2);
        chk("R6 osc_en", osc_en, 1);
        chk("R6 src_sel kept", src_sel, 0);

        // R8: writes ignored during stop
        drive(1, 1, 0, 1, 0, 0); step();
        chk("R8 src_sel unchanged", src_sel, 0);
        drive(0, 0, 0, 1, 0, 1); step();
        chk("R8 src_sel after wake", src_sel, 0);
        drive(0, 0, 0, 1, 1, 0); step();
        chk("R8 pseudo bit kept", mode, 2);
        drive(0, 0, 0, 1, 0, 1); step();

        // R10: clear on the same edge as full-stop entry
        drive(1, 0, 0, 1, 0, 0); step();
        chk("R10 setup", src_sel, 0);
        drive(1, 0, 0, 1, 1, 0); step();
        chk("R10 mode full", mode, 1);
        chk("R10 hardware set wins", src_sel, 1);
        drive(0, 0, 0, 1, 0, 1); step();

        // Sweep across all input combinations against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 6000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr[7], lfsr[8], lfsr[9], lfsr[3:0] != 4'd0,
                  lfsr[4] & lfsr[5], lfsr[6]);
            step();
            chk("R7 sweep mode", mode, m_mode);
            chk("R4 sweep src_sel", src_sel, m_sel);
            chk("R5 sweep osc_en", osc_en, (m_mode == 1) ? 0 : 1);
            chk("R9 sweep bus_ce", bus_ce, exp_ce());
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule